// File: doc/BRIEF.md
# Multi-phase memory command steerer

This block sits between a controller's command arbitration and a multi-phase memory PHY command interface. Every controller clock carries several PHY phases. For each phase, a two-bit select input picks one of four command sources: an idle no-operation, a general command channel, a read/write request channel and a refresh channel. The chosen source's active-high row-strobe, column-strobe and write-enable bits go out as active-low strobes. They are passed on only when that source presents both valid and ready, so a command reaches the memory only in the cycle of its handshake.

The source's bank field is split in two. The upper bits name a rank, which becomes a one-hot active-low chip select. The lower bits become the bank address. A refresh steered to a phase selects every rank at once. Reset, clock-enable and termination outputs are held statically asserted. All phase outputs are registered, so they appear one clock after the select and handshake.

The number of phases, ranks, address bits and bank bits are parameters. The rank count is 1 or a power of two.

Top module: `cmd_phase_steer`

## Requirements
- R1: Phase p takes its source from sel_i[2p+1:2p]: 0 = idle, 1 = command channel, 2 = request channel, 3 = refresh channel. Each phase selects independently of the others.
- R2: A phase that selects idle (0) drives ras_n, cas_n and we_n as 1, all of its cs_n bits as 1, and address and bank as 0.
- R3: When the selected source has valid and ready both 1, the phase drives ras_n, cas_n and we_n as the inverse of that source's ras, cas and we bits.
- R4: When the selected source lacks valid or ready, ras_n, cas_n and we_n stay 1, while address and bank still follow that source.
- R5: With one rank, the whole bank field goes to the phase bank output, and cs_n is 0 for any source other than idle.
- R6: With several ranks, the upper log2(ranks) bits of the bank field select the rank and the remaining low bits form the bank output. Rank r drives cs_n bit r low and all other bits high. For example, with 2 ranks and 3 bank bits, 0b110 gives bank 0b10 and cs_n 0b01, and 0b001 gives bank 0b01 and cs_n 0b10.
- R7: A phase that selects refresh drives every cs_n bit to 0, whatever the rank bits hold. The bank output is still the low bank bits.
- R8: reset_n is 1 on every phase, and cke and odt are 1 for every rank on every phase, at all times including reset.
- R9: Phase outputs change one clock after the select and source inputs that cause them, never in the same cycle.
- R10: While rst_ni is low, every phase shows the idle state of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 2*NUM_PHASES | Per-phase source select |
| cmd_valid_i | input | 1 | Command channel valid |
| cmd_ready_i | input | 1 | Command channel ready |
| cmd_ras_i | input | 1 | Command channel row strobe |
| cmd_cas_i | input | 1 | Command channel column strobe |
| cmd_we_i | input | 1 | Command channel write enable |
| cmd_addr_i | input | ADDR_W | Command channel address |
| cmd_bank_i | input | BANK_W | Command channel bank field |
| req_valid_i | input | 1 | Request channel valid |
| req_ready_i | input | 1 | Request channel ready |
| req_ras_i | input | 1 | Request channel row strobe |
| req_cas_i | input | 1 | Request channel column strobe |
| req_we_i | input | 1 | Request channel write enable |
| req_addr_i | input | ADDR_W | Request channel address |
| req_bank_i | input | BANK_W | Request channel bank field |
| ref_valid_i | input | 1 | Refresh channel valid |
| ref_ready_i | input | 1 | Refresh channel ready |
| ref_ras_i | input | 1 | Refresh channel row strobe |
| ref_cas_i | input | 1 | Refresh channel column strobe |
| ref_we_i | input | 1 | Refresh channel write enable |
| ref_addr_i | input | ADDR_W | Refresh channel address |
| ref_bank_i | input | BANK_W | Refresh channel bank field |
| cs_n_o | output | NUM_PHASES*NUM_RANKS | Per-phase active-low chip selects |
| ras_n_o | output | NUM_PHASES | Per-phase active-low row strobe |
| cas_n_o | output | NUM_PHASES | Per-phase active-low column strobe |
| we_n_o | output | NUM_PHASES | Per-phase active-low write enable |
| addr_o | output | NUM_PHASES*ADDR_W | Per-phase address |
| bank_o | output | NUM_PHASES*(BANK_W-log2(NUM_RANKS)) | Per-phase bank address |
| reset_n_o | output | NUM_PHASES | Per-phase memory reset, held high |
| cke_o | output | NUM_PHASES*NUM_RANKS | Per-phase, per-rank clock enable, held high |
| odt_o | output | NUM_PHASES*NUM_RANKS | Per-phase, per-rank termination, held high |

## Verification
The only state is the output register of each phase. A wrong value there shows at the ports in the very next cycle, and is overwritten one cycle later. A select decode fault appears as strobes or a chip select on the wrong phase. A missing handshake gate appears as a low strobe while ready is low. A fault in rank slicing appears as a wrong cs_n bit or wrong bank bits for bank values that differ only in their top bits. The bench therefore drives the select and handshake in one cycle and compares every phase output exactly one edge later. It checks the single-rank and multi-rank variants with two instances side by side.

// File: rtl/steer_pkg.sv
package steer_pkg;
  typedef enum logic [1:0] {
    SRC_NOP = 2'd0,
    SRC_CMD = 2'd1,
    SRC_REQ = 2'd2,
    SRC_REF = 2'd3
  } src_sel_e;

  localparam int NUM_SRC = 4;
endpackage

// File: rtl/steer_src_mux.sv
module steer_src_mux
  import steer_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BANK_W = 3
) (
  input  src_sel_e                    sel_i,
  input  logic [NUM_SRC-1:0]          valid_i,
  input  logic [NUM_SRC-1:0]          ready_i,
  input  logic [NUM_SRC-1:0]          ras_i,
  input  logic [NUM_SRC-1:0]          cas_i,
  input  logic [NUM_SRC-1:0]          we_i,
  input  logic [NUM_SRC*ADDR_W-1:0]   addr_i,
  input  logic [NUM_SRC*BANK_W-1:0]   bank_i,
  output logic                        ras_n_o,
  output logic                        cas_n_o,
  output logic                        we_n_o,
  output logic [ADDR_W-1:0]           addr_o,
  output logic [BANK_W-1:0]           bank_o,
  output logic                        nop_o,
  output logic                        ref_o
);
  logic [1:0] idx;
  logic       fire;

  always_comb begin
    idx     = sel_i;
    fire    = valid_i[idx] & ready_i[idx];
    ras_n_o = ~(fire & ras_i[idx]);
    cas_n_o = ~(fire & cas_i[idx]);
    we_n_o  = ~(fire & we_i[idx]);
    addr_o  = addr_i[idx*ADDR_W +: ADDR_W];
    bank_o  = bank_i[idx*BANK_W +: BANK_W];
    nop_o   = (sel_i == SRC_NOP);
    ref_o   = (sel_i == SRC_REF);
  end
endmodule

// File: rtl/steer_rank_decode.sv
module steer_rank_decode #(
  parameter int NUM_RANKS = 2,
  parameter int BANK_W    = 3,
  localparam int RANK_BITS  = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 0,
  localparam int PHY_BANK_W = BANK_W - RANK_BITS
) (
  input  logic [BANK_W-1:0]     bank_i,
  input  logic                  nop_i,
  input  logic                  ref_i,
  output logic [PHY_BANK_W-1:0] bank_o,
  output logic [NUM_RANKS-1:0]  cs_n_o
);
  if (RANK_BITS == 0) begin : g_single
    always_comb begin
      bank_o = bank_i;
      cs_n_o = {NUM_RANKS{nop_i}};
    end
  end else begin : g_multi
    logic [RANK_BITS-1:0] rank;
    always_comb begin
      rank   = bank_i[BANK_W-1 -: RANK_BITS];
      bank_o = bank_i[PHY_BANK_W-1:0];
      cs_n_o = '1;
      for (int r = 0; r < NUM_RANKS; r++) begin
        if (rank == RANK_BITS'(r)) cs_n_o[r] = 1'b0;
      end
      if (ref_i) cs_n_o = '0;   // refresh hits every rank
      if (nop_i) cs_n_o = '1;
    end
  end
endmodule

// File: rtl/steer_phase_reg.sv
module steer_phase_reg #(
  parameter int ADDR_W     = 13,
  parameter int PHY_BANK_W = 2,
  parameter int NUM_RANKS  = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ras_n_i,
  input  logic                  cas_n_i,
  input  logic                  we_n_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [PHY_BANK_W-1:0] bank_i,
  input  logic [NUM_RANKS-1:0]  cs_n_i,
  output logic                  ras_n_o,
  output logic                  cas_n_o,
  output logic                  we_n_o,
  output logic [ADDR_W-1:0]     addr_o,
  output logic [PHY_BANK_W-1:0] bank_o,
  output logic [NUM_RANKS-1:0]  cs_n_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_n_o <= 1'b1;
      cas_n_o <= 1'b1;
      we_n_o  <= 1'b1;
      addr_o  <= '0;
      bank_o  <= '0;
      cs_n_o  <= '1;
    end else begin
      ras_n_o <= ras_n_i;
      cas_n_o <= cas_n_i;
      we_n_o  <= we_n_i;
      addr_o  <= addr_i;
      bank_o  <= bank_i;
      cs_n_o  <= cs_n_i;
    end
  end
endmodule

// File: rtl/cmd_phase_steer.sv
module cmd_phase_steer
  import steer_pkg::*;
#(
  parameter int NUM_PHASES = 2,
  parameter int NUM_RANKS  = 2,
  parameter int ADDR_W     = 13,
  parameter int BANK_W     = 3,
  localparam int RANK_BITS  = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 0,
  localparam int PHY_BANK_W = BANK_W - RANK_BITS
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [2*NUM_PHASES-1:0]          sel_i,
  input  logic                             cmd_valid_i,
  input  logic                             cmd_ready_i,
  input  logic                             cmd_ras_i,
  input  logic                             cmd_cas_i,
  input  logic                             cmd_we_i,
  input  logic [ADDR_W-1:0]                cmd_addr_i,
  input  logic [BANK_W-1:0]                cmd_bank_i,
  input  logic                             req_valid_i,
  input  logic                             req_ready_i,
  input  logic                             req_ras_i,
  input  logic                             req_cas_i,
  input  logic                             req_we_i,
  input  logic [ADDR_W-1:0]                req_addr_i,
  input  logic [BANK_W-1:0]                req_bank_i,
  input  logic                             ref_valid_i,
  input  logic                             ref_ready_i,
  input  logic                             ref_ras_i,
  input  logic                             ref_cas_i,
  input  logic                             ref_we_i,
  input  logic [ADDR_W-1:0]                ref_addr_i,
  input  logic [BANK_W-1:0]                ref_bank_i,
  output logic [NUM_PHASES*NUM_RANKS-1:0]  cs_n_o,
  output logic [NUM_PHASES-1:0]            ras_n_o,
  output logic [NUM_PHASES-1:0]            cas_n_o,
  output logic [NUM_PHASES-1:0]            we_n_o,
  output logic [NUM_PHASES*ADDR_W-1:0]     addr_o,
  output logic [NUM_PHASES*PHY_BANK_W-1:0] bank_o,
  output logic [NUM_PHASES-1:0]            reset_n_o,
  output logic [NUM_PHASES*NUM_RANKS-1:0]  cke_o,
  output logic [NUM_PHASES*NUM_RANKS-1:0]  odt_o
);
  // source index 0 is the idle source: never valid, zero fields
  logic [NUM_SRC-1:0]        src_valid, src_ready, src_ras, src_cas, src_we;
  logic [NUM_SRC*ADDR_W-1:0] src_addr;
  logic [NUM_SRC*BANK_W-1:0] src_bank;

  assign src_valid = {ref_valid_i, req_valid_i, cmd_valid_i, 1'b0};
  assign src_ready = {ref_ready_i, req_ready_i, cmd_ready_i, 1'b0};
  assign src_ras   = {ref_ras_i, req_ras_i, cmd_ras_i, 1'b0};
  assign src_cas   = {ref_cas_i, req_cas_i, cmd_cas_i, 1'b0};
  assign src_we    = {ref_we_i, req_we_i, cmd_we_i, 1'b0};
  assign src_addr  = {ref_addr_i, req_addr_i, cmd_addr_i, {ADDR_W{1'b0}}};
  assign src_bank  = {ref_bank_i, req_bank_i, cmd_bank_i, {BANK_W{1'b0}}};

  assign reset_n_o = '1;
  assign cke_o     = '1;
  assign odt_o     = '1;

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
    src_sel_e              sel;
    logic                  ras_n, cas_n, we_n, is_nop, is_ref;
    logic [ADDR_W-1:0]     addr;
    logic [BANK_W-1:0]     bank_full;
    logic [PHY_BANK_W-1:0] bank;
    logic [NUM_RANKS-1:0]  cs_n;

    assign sel = src_sel_e'(sel_i[2*p +: 2]);

    steer_src_mux #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_mux (
      .sel_i   (sel),
      .valid_i (src_valid),
      .ready_i (src_ready),
      .ras_i   (src_ras),
      .cas_i   (src_cas),
      .we_i    (src_we),
      .addr_i  (src_addr),
      .bank_i  (src_bank),
      .ras_n_o (ras_n),
      .cas_n_o (cas_n),
      .we_n_o  (we_n),
      .addr_o  (addr),
      .bank_o  (bank_full),
      .nop_o   (is_nop),
      .ref_o   (is_ref)
    );

    steer_rank_decode #(.NUM_RANKS(NUM_RANKS), .BANK_W(BANK_W)) u_rank (
      .bank_i (bank_full),
      .nop_i  (is_nop),
      .ref_i  (is_ref),
      .bank_o (bank),
      .cs_n_o (cs_n)
    );

    steer_phase_reg #(
      .ADDR_W(ADDR_W), .PHY_BANK_W(PHY_BANK_W), .NUM_RANKS(NUM_RANKS)
    ) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ras_n_i (ras_n),
      .cas_n_i (cas_n),
      .we_n_i  (we_n),
      .addr_i  (addr),
      .bank_i  (bank),
      .cs_n_i  (cs_n),
      .ras_n_o (ras_n_o[p]),
      .cas_n_o (cas_n_o[p]),
      .we_n_o  (we_n_o[p]),
      .addr_o  (addr_o[p*ADDR_W +: ADDR_W]),
      .bank_o  (bank_o[p*PHY_BANK_W +: PHY_BANK_W]),
      .cs_n_o  (cs_n_o[p*NUM_RANKS +: NUM_RANKS])
    );
  end
endmodule

// File: rtl/steer_checker.sv
module steer_checker #(
  parameter int NUM_PHASES = 2,
  parameter int NUM_RANKS  = 2,
  parameter int ADDR_W     = 13,
  parameter int BANK_W     = 3,
  localparam int RANK_BITS  = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 0,
  localparam int PHY_BANK_W = BANK_W - RANK_BITS
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic [2*NUM_PHASES-1:0]          sel_i,
  input logic                             cmd_valid_i,
  input logic                             cmd_ready_i,
  input logic                             cmd_ras_i,
  input logic                             cmd_cas_i,
  input logic                             cmd_we_i,
  input logic [ADDR_W-1:0]                cmd_addr_i,
  input logic [BANK_W-1:0]                cmd_bank_i,
  input logic                             req_valid_i,
  input logic                             req_ready_i,
  input logic                             req_ras_i,
  input logic                             req_cas_i,
  input logic                             req_we_i,
  input logic [ADDR_W-1:0]                req_addr_i,
  input logic [BANK_W-1:0]                req_bank_i,
  input logic                             ref_valid_i,
  input logic                             ref_ready_i,
  input logic                             ref_ras_i,
  input logic                             ref_cas_i,
  input logic                             ref_we_i,
  input logic [ADDR_W-1:0]                ref_addr_i,
  input logic [BANK_W-1:0]                ref_bank_i,
  input logic [NUM_PHASES*NUM_RANKS-1:0]  cs_n_o,
  input logic [NUM_PHASES-1:0]            ras_n_o,
  input logic [NUM_PHASES-1:0]            cas_n_o,
  input logic [NUM_PHASES-1:0]            we_n_o,
  input logic [NUM_PHASES*ADDR_W-1:0]     addr_o,
  input logic [NUM_PHASES*PHY_BANK_W-1:0] bank_o,
  input logic [NUM_PHASES-1:0]            reset_n_o,
  input logic [NUM_PHASES*NUM_RANKS-1:0]  cke_o,
  input logic [NUM_PHASES*NUM_RANKS-1:0]  odt_o
);
  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_chk
    assert_nop_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i[2*p +: 2] == 2'd0) |=>
        (ras_n_o[p] && cas_n_o[p] && we_n_o[p] && (cs_n_o[p*NUM_RANKS +: NUM_RANKS] == '1)));

    assert_cmd_fire_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i[2*p +: 2] == 2'd1 && cmd_valid_i && cmd_ready_i) |=>
        (ras_n_o[p] == !$past(cmd_ras_i) && cas_n_o[p] == !$past(cmd_cas_i) &&
         we_n_o[p] == !$past(cmd_we_i)));

    assert_req_gated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i[2*p +: 2] == 2'd2 && !(req_valid_i && req_ready_i)) |=>
        (ras_n_o[p] && cas_n_o[p] && we_n_o[p] &&
         addr_o[p*ADDR_W +: ADDR_W] == $past(req_addr_i)));

    assert_ref_all_ranks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i[2*p +: 2] == 2'd3) |=> (cs_n_o[p*NUM_RANKS +: NUM_RANKS] == '0));

    assert_one_rank_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i[2*p +: 2] == 2'd1 || sel_i[2*p +: 2] == 2'd2) |=>
        ($countones(cs_n_o[p*NUM_RANKS +: NUM_RANKS]) == NUM_RANKS - 1));
  end
endmodule

bind cmd_phase_steer steer_checker #(
  .NUM_PHASES(NUM_PHASES), .NUM_RANKS(NUM_RANKS), .ADDR_W(ADDR_W), .BANK_W(BANK_W)
) u_steer_checker (.*);

// File: tb/tb_cmd_phase_steer.sv
`timescale 1ns/1ps
module tb_cmd_phase_steer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  sel_i = '0;
  logic        cmd_valid_i = 0, cmd_ready_i = 0, cmd_ras_i = 0, cmd_cas_i = 0, cmd_we_i = 0;
  logic [12:0] cmd_addr_i = '0;
  logic [2:0]  cmd_bank_i = '0;
  logic        req_valid_i = 0, req_ready_i = 0, req_ras_i = 0, req_cas_i = 0, req_we_i = 0;
  logic [12:0] req_addr_i = '0;
  logic [2:0]  req_bank_i = '0;
  logic        ref_valid_i = 0, ref_ready_i = 0, ref_ras_i = 0, ref_cas_i = 0, ref_we_i = 0;
  logic [12:0] ref_addr_i = '0;
  logic [2:0]  ref_bank_i = '0;

  logic [3:0]  cs_n_o, cke_o, odt_o;
  logic [1:0]  ras_n_o, cas_n_o, we_n_o, reset_n_o;
  logic [25:0] addr_o;
  logic [3:0]  bank_o;

  logic [1:0]  cs1_n_o, cke1_o, odt1_o;
  logic [1:0]  ras1_n_o, cas1_n_o, we1_n_o, reset1_n_o;
  logic [25:0] addr1_o;
  logic [5:0]  bank1_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  cmd_phase_steer #(.NUM_PHASES(2), .NUM_RANKS(2), .ADDR_W(13), .BANK_W(3)) dut (
    .clk_i, .rst_ni, .sel_i,
    .cmd_valid_i, .cmd_ready_i, .cmd_ras_i, .cmd_cas_i, .cmd_we_i, .cmd_addr_i, .cmd_bank_i,
    .req_valid_i, .req_ready_i, .req_ras_i, .req_cas_i, .req_we_i, .req_addr_i, .req_bank_i,
    .ref_valid_i, .ref_ready_i, .ref_ras_i, .ref_cas_i, .ref_we_i, .ref_addr_i, .ref_bank_i,
    .cs_n_o, .ras_n_o, .cas_n_o, .we_n_o, .addr_o, .bank_o, .reset_n_o, .cke_o, .odt_o
  );

  cmd_phase_steer #(.NUM_PHASES(2), .NUM_RANKS(1), .ADDR_W(13), .BANK_W(3)) dut1 (
    .clk_i, .rst_ni, .sel_i,
    .cmd_valid_i, .cmd_ready_i, .cmd_ras_i, .cmd_cas_i, .cmd_we_i, .cmd_addr_i, .cmd_bank_i,
    .req_valid_i, .req_ready_i, .req_ras_i, .req_cas_i, .req_we_i, .req_addr_i, .req_bank_i,
    .ref_valid_i, .ref_ready_i, .ref_ras_i, .ref_cas_i, .ref_we_i, .ref_addr_i, .ref_bank_i,
    .cs_n_o(cs1_n_o), .ras_n_o(ras1_n_o), .cas_n_o(cas1_n_o), .we_n_o(we1_n_o),
    .addr_o(addr1_o), .bank_o(bank1_o), .reset_n_o(reset1_n_o), .cke_o(cke1_o), .odt_o(odt1_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic set_cmd(input logic v, input logic r, input logic ras, input logic cas,
                         input logic we, input logic [12:0] a, input logic [2:0] b);
    cmd_valid_i = v; cmd_ready_i = r; cmd_ras_i = ras; cmd_cas_i = cas; cmd_we_i = we;
    cmd_addr_i = a; cmd_bank_i = b;
  endtask

  task automatic set_req(input logic v, input logic r, input logic ras, input logic cas,
                         input logic we, input logic [12:0] a, input logic [2:0] b);
    req_valid_i = v; req_ready_i = r; req_ras_i = ras; req_cas_i = cas; req_we_i = we;
    req_addr_i = a; req_bank_i = b;
  endtask

  task automatic set_ref(input logic v, input logic r, input logic ras, input logic cas,
                         input logic we, input logic [12:0] a, input logic [2:0] b);
    ref_valid_i = v; ref_ready_i = r; ref_ras_i = ras; ref_cas_i = cas; ref_we_i = we;
    ref_addr_i = a; ref_bank_i = b;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    set_cmd(1, 1, 1, 0, 0, 13'h1f, 3'b110);
    sel_i = 4'b0101;
    step();
    chk("R10 ras_n in reset", ras_n_o, 2'b11);
    chk("R10 cs_n in reset", cs_n_o, 4'hf);
    chk("R10 addr in reset", addr_o, 26'h0);
    chk("R8 reset_n", reset_n_o, 2'b11);
    chk("R8 cke", cke_o, 4'hf);
    chk("R8 odt", odt_o, 4'hf);
    @(negedge clk_i);
    rst_ni = 1'b1;
    sel_i = 4'b0000;
  endtask

  task automatic t_nop_r2();
    @(negedge clk_i);
    set_cmd(1, 1, 1, 1, 1, 13'h77, 3'b111);
    set_req(1, 1, 1, 1, 1, 13'h66, 3'b111);
    sel_i = 4'b0000;
    step();
    chk("R2 ras_n", ras_n_o, 2'b11);
    chk("R2 cas_n", cas_n_o, 2'b11);
    chk("R2 we_n", we_n_o, 2'b11);
    chk("R2 cs_n", cs_n_o, 4'hf);
    chk("R2 addr", addr_o, 26'h0);
    chk("R2 bank", bank_o, 4'h0);
  endtask

  task automatic t_fire_r3();
    @(negedge clk_i);
    set_req(0, 0, 0, 0, 0, 13'h0, 3'b0);
    set_cmd(1, 1, 1, 0, 0, 13'h55, 3'b110);
    sel_i = 4'b0100;  // phase0 idle, phase1 command channel
    step();
    chk("R3 ras_n", ras_n_o, 2'b01);
    chk("R3 cas_n", cas_n_o, 2'b11);
    chk("R3 we_n", we_n_o, 2'b11);
    chk("R1 phase1 addr", addr_o[25:13], 13'h55);
    chk("R6 bank 110", bank_o[3:2], 2'b10);
    chk("R6 cs_n rank1", cs_n_o, 4'b0111);
    chk("R5 single rank bank", bank1_o[5:3], 3'b110);
    chk("R5 single rank cs_n", cs1_n_o, 2'b01);
  endtask

  task automatic t_gate_r4();
    @(negedge clk_i);
    set_cmd(1, 0, 1, 1, 1, 13'h99, 3'b110);
    sel_i = 4'b0100;
    step();
    chk("R4 not ready strobes", {ras_n_o, cas_n_o, we_n_o}, 6'h3f);
    chk("R4 not ready addr", addr_o[25:13], 13'h99);
    @(negedge clk_i);
    set_cmd(0, 1, 1, 1, 1, 13'h3a, 3'b001);
    step();
    chk("R4 not valid strobes", {ras_n_o, cas_n_o, we_n_o}, 6'h3f);
    chk("R4 not valid addr", addr_o[25:13], 13'h3a);
    chk("R4 not valid bank", bank_o[3:2], 2'b01);
  endtask

  task automatic t_rank_r6();
    @(negedge clk_i);
    set_cmd(1, 1, 1, 0, 0, 13'h4, 3'b001);
    sel_i = 4'b0100;
    step();
    chk("R6 bank 001", bank_o[3:2], 2'b01);
    chk("R6 cs_n rank0", cs_n_o[3:2], 2'b10);
    @(negedge clk_i);
    cmd_bank_i = 3'b101;
    step();
    chk("R6 bank 101", bank_o[3:2], 2'b01);
    chk("R6 cs_n 101", cs_n_o[3:2], 2'b01);
  endtask

  task automatic t_ref_r7();
    @(negedge clk_i);
    set_cmd(0, 0, 0, 0, 0, 13'h0, 3'b0);
    set_ref(1, 1, 1, 1, 0, 13'h0, 3'b110);
    sel_i = 4'b0011;  // phase0 refresh, phase1 idle
    step();
    chk("R7 ras_n", ras_n_o, 2'b10);
    chk("R7 cas_n", cas_n_o, 2'b10);
    chk("R7 we_n", we_n_o, 2'b11);
    chk("R7 cs_n all ranks", cs_n_o, 4'b1100);
    chk("R7 bank", bank_o[1:0], 2'b10);
    @(negedge clk_i);
    set_ref(1, 0, 1, 1, 0, 13'h0, 3'b001);
    step();
    chk("R7 cs_n without handshake", cs_n_o[1:0], 2'b00);
    chk("R4 refresh not ready", ras_n_o[0], 1'b1);
  endtask

  task automatic t_mixed_r1();
    @(negedge clk_i);
    set_req(1, 1, 0, 1, 1, 13'h12, 3'b101);
    set_ref(1, 1, 1, 1, 0, 13'h0, 3'b000);
    sel_i = 4'b1110;  // phase0 request, phase1 refresh
    step();
    chk("R1 cas_n", cas_n_o, 2'b00);
    chk("R1 ras_n", ras_n_o, 2'b01);
    chk("R1 we_n", we_n_o, 2'b10);
    chk("R1 cs_n", cs_n_o, 4'b0001);
    chk("R1 phase0 addr", addr_o[12:0], 13'h12);
    chk("R1 phase0 bank", bank_o[1:0], 2'b01);
  endtask

  task automatic t_latency_r9();
    @(negedge clk_i);
    set_req(0, 0, 0, 0, 0, 13'h0, 3'b0);
    set_ref(0, 0, 0, 0, 0, 13'h0, 3'b0);
    sel_i = 4'b0000;
    step();
    @(negedge clk_i);
    set_cmd(1, 1, 1, 0, 1, 13'h21, 3'b010);
    sel_i = 4'b0001;
    #1;
    chk("R9 no same-cycle change", {ras_n_o, we_n_o, cs_n_o}, 8'hff);
    step();
    chk("R9 ras_n after edge", ras_n_o, 2'b10);
    chk("R9 we_n after edge", we_n_o, 2'b10);
    chk("R9 cs_n after edge", cs_n_o, 4'b1110);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_nop_r2();
    t_fire_r3();
    t_gate_r4();
    t_rank_r6();
    t_ref_r7();
    t_mixed_r1();
    t_latency_r9();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule